// File: doc/BRIEF.md
# Masked Register Readback Sequencer

This block answers processor I/O reads on the data port of a single-channel DMA engine. It returns one byte per read, taken live from the engine's byte counter, its port A pointer, its port B pointer, or a status placeholder. A 7-bit selection mask decides which of these seven byte-wide views take part. Each completed read moves on to the next selected view, and after the last one it wraps back to the first.

Software programs the mask in two steps on the same port. It first writes the arming command byte (0xBB by default). The byte written next becomes the mask. The mask is all ones after reset, so a fresh engine presents all seven views in turn.

Top module: `rbseq_readback`

## Requirements
- R1: After reset the mask selects all seven views, and the first read returns the status byte (the `STATUS_BYTE` parameter). Reads that follow return counter low and then counter high.
- R2: A write of `ARM_CODE` (0xBB) arms the block, and the next write, whatever its value, loads its bits 6:0 as the mask. Bit 7 of that write is ignored. A write made while the block is not armed never changes the mask.
- R3: Mask bit positions and view order are fixed: bit 0 status, bit 1 counter bits 7:0, bit 2 counter bits 15:8, bit 3 port A pointer bits 7:0, bit 4 port A pointer bits 15:8, bit 5 port B pointer bits 7:0, bit 6 port B pointer bits 15:8.
- R4: Each completed read moves to the next selected view in ascending bit order. After the highest selected view it wraps to the lowest, and this repeats without limit.
- R5: Loading a mask returns the sequence to the lowest selected view, even in the middle of a sequence.
- R6: While the mask is zero, every read returns 0x00.
- R7: `rd_data` follows the counter and pointer inputs in the same cycle, with no read needed to refresh it.
- R8: A read strobe held high for any number of cycles keeps `rd_data` steady. It advances the sequence exactly once, in the cycle after the strobe is first seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Port write strobe, one cycle per write |
| wr_data | input | 8 | Port write data |
| rd_stb | input | 1 | Port read strobe; the read completes when it drops |
| byte_cnt | input | CNT_W | Live byte counter of the engine |
| ptr_a | input | ADDR_W | Next address of port A |
| ptr_b | input | ADDR_W | Next address of port B |
| rd_data | output | 8 | Byte of the current view |

## Verification
The checker assumes that writes and reads never overlap. It also assumes that `rd_stb` is low during reset, and that the counter and pointer inputs only move when the stability property does not apply. The bench drives every strobe from tasks on the falling clock edge, one transaction at a time, with one idle edge between transactions. It changes the live inputs only between strobes, except in the deliberate R7 check. The sweep loads all 128 mask values and reads enough times to wrap every subset at least once. The value of bit 7 alternates across the sweep.

// File: rtl/rbseq_pkg.sv
package rbseq_pkg;
   localparam int unsigned NSLOT = 7;
   typedef logic [NSLOT-1:0] sel_mask_t;
   typedef logic [2:0]       slot_idx_t;

   // Slot numbering doubles as mask bit position.
   typedef enum slot_idx_t {
      SL_STATUS = 3'd0,
      SL_CNT_LO = 3'd1,
      SL_CNT_HI = 3'd2,
      SL_A_LO   = 3'd3,
      SL_A_HI   = 3'd4,
      SL_B_LO   = 3'd5,
      SL_B_HI   = 3'd6
   } slot_e;

   function automatic slot_idx_t lowest_sel(sel_mask_t m);
      slot_idx_t r = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (m[i]) r = slot_idx_t'(i);
      end
      return r;
   endfunction

   // Next selected slot strictly after cur, wrapping; cur itself if alone.
   function automatic slot_idx_t next_sel(sel_mask_t m, slot_idx_t cur);
      slot_idx_t r = cur;
      logic      found = 1'b0;
      for (int off = 1; off <= NSLOT; off++) begin
         int c = int'(cur) + off;
         if (c >= NSLOT) c = c - NSLOT;
         if (!found && m[c]) begin
            r     = slot_idx_t'(c);
            found = 1'b1;
         end
      end
      return r;
   endfunction
endpackage

// File: rtl/rbseq_cmd.sv
module rbseq_cmd
   import rbseq_pkg::*;
#(
   parameter logic [7:0] ARM_CODE   = 8'hBB,
   parameter sel_mask_t  RESET_MASK = '1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic [7:0] wr_data,
   output logic       arm_q,
   output logic       load,
   output sel_mask_t  new_mask,
   output sel_mask_t  mask_q
);
   assign load     = wr_stb & arm_q;
   assign new_mask = wr_data[NSLOT-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q  <= 1'b0;
         mask_q <= RESET_MASK;
      end else if (wr_stb) begin
         if (arm_q) begin
            mask_q <= new_mask;
            arm_q  <= 1'b0;
         end else begin
            arm_q  <= (wr_data == ARM_CODE);
         end
      end
   end
endmodule

// File: rtl/rbseq_ptr.sv
module rbseq_ptr
   import rbseq_pkg::*;
#(
   parameter sel_mask_t RESET_MASK = '1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rd_stb,
   input  sel_mask_t mask_q,
   input  logic      load,
   input  sel_mask_t new_mask,
   output slot_idx_t ptr_q
);
   logic strb_q;
   logic done;

   assign done = strb_q & ~rd_stb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strb_q <= 1'b0;
         ptr_q  <= lowest_sel(RESET_MASK);
      end else begin
         strb_q <= rd_stb;
         if (load)
            ptr_q <= lowest_sel(new_mask);
         else if (done && (mask_q != '0))
            ptr_q <= next_sel(mask_q, ptr_q);
      end
   end
endmodule

// File: rtl/rbseq_mux.sv
module rbseq_mux
   import rbseq_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned ADDR_W      = 16,
   parameter logic [7:0]  STATUS_BYTE = 8'h00
) (
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic [ADDR_W-1:0] ptr_a,
   input  logic [ADDR_W-1:0] ptr_b,
   input  slot_idx_t         ptr_q,
   input  logic              any_sel,
   output logic [7:0]        rd_data
);
   logic [15:0] cnt16, a16, b16;

   generate
      if (CNT_W < 16) begin : g_cnt_pad
         assign cnt16 = {{(16 - CNT_W){1'b0}}, byte_cnt};
      end else begin : g_cnt_full
         assign cnt16 = byte_cnt;
      end
      if (ADDR_W < 16) begin : g_addr_pad
         assign a16 = {{(16 - ADDR_W){1'b0}}, ptr_a};
         assign b16 = {{(16 - ADDR_W){1'b0}}, ptr_b};
      end else begin : g_addr_full
         assign a16 = ptr_a;
         assign b16 = ptr_b;
      end
   endgenerate

   always_comb begin
      rd_data = 8'h00;
      if (any_sel) begin
         case (ptr_q)
            SL_STATUS: rd_data = STATUS_BYTE;
            SL_CNT_LO: rd_data = cnt16[7:0];
            SL_CNT_HI: rd_data = cnt16[15:8];
            SL_A_LO:   rd_data = a16[7:0];
            SL_A_HI:   rd_data = a16[15:8];
            SL_B_LO:   rd_data = b16[7:0];
            SL_B_HI:   rd_data = b16[15:8];
            default:   rd_data = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/rbseq_readback.sv
module rbseq_readback
   import rbseq_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned ADDR_W      = 16,
   parameter logic [7:0]  ARM_CODE    = 8'hBB,
   parameter logic [7:0]  STATUS_BYTE = 8'h00,
   parameter sel_mask_t   RESET_MASK  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [7:0]        wr_data,
   input  logic              rd_stb,
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic [ADDR_W-1:0] ptr_a,
   input  logic [ADDR_W-1:0] ptr_b,
   output logic [7:0]        rd_data
);
   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("rbseq_readback: CNT_W must lie in 1..16");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("rbseq_readback: ADDR_W must lie in 1..16");
      end
   endgenerate

   logic      arm_q;
   logic      load;
   sel_mask_t new_mask;
   sel_mask_t mask_q;
   slot_idx_t ptr_q;

   rbseq_cmd #(.ARM_CODE(ARM_CODE), .RESET_MASK(RESET_MASK)) cmd_i (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .arm_q(arm_q), .load(load), .new_mask(new_mask), .mask_q(mask_q)
   );

   rbseq_ptr #(.RESET_MASK(RESET_MASK)) ptr_i (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mask_q(mask_q),
      .load(load), .new_mask(new_mask), .ptr_q(ptr_q)
   );

   rbseq_mux #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .STATUS_BYTE(STATUS_BYTE)) mux_i (
      .byte_cnt(byte_cnt), .ptr_a(ptr_a), .ptr_b(ptr_b),
      .ptr_q(ptr_q), .any_sel(mask_q != '0), .rd_data(rd_data)
   );
endmodule

// File: rtl/rbseq_readback_chk.sv
module rbseq_readback_chk
   import rbseq_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic [7:0]        wr_data,
   input logic              rd_stb,
   input logic [CNT_W-1:0]  byte_cnt,
   input logic [ADDR_W-1:0] ptr_a,
   input logic [ADDR_W-1:0] ptr_b,
   input logic [7:0]        rd_data,
   input logic              arm_q,
   input sel_mask_t         mask_q,
   input slot_idx_t         ptr_q
);
   sel_mask_t below;
   assign below = mask_q & ~(sel_mask_t'('1) << ptr_q);

   // R2: armed write becomes the mask
   a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && wr_stb) |=> (mask_q == $past(wr_data[NSLOT-1:0])));

   // R5: after a load the pointer sits on the lowest selected slot
   a_r5_lowest_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && wr_stb) |=> ((mask_q == '0) || (mask_q[ptr_q] && below == '0)));

   // R4: pointer only ever rests on a selected slot
   a_r4_on_selected: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q != '0) |-> (ptr_q < 3'(NSLOT) && mask_q[ptr_q]));

   // R6: empty mask reads zero
   a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> (rd_data == 8'h00));

   // R8: held strobe with quiet inputs keeps the data steady
   a_r8_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && $past(rd_stb) && !$past(wr_stb) && $stable(byte_cnt)
       && $stable(ptr_a) && $stable(ptr_b)) |-> $stable(rd_data));
endmodule

bind rbseq_readback rbseq_readback_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
   .rd_stb(rd_stb), .byte_cnt(byte_cnt), .ptr_a(ptr_a), .ptr_b(ptr_b),
   .rd_data(rd_data), .arm_q(arm_q), .mask_q(mask_q), .ptr_q(ptr_q)
);

// File: tb/rbseq_readback_tb.sv
module rbseq_readback_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] STAT = 8'h5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic        rd_stb = 1'b0;
   logic [15:0] byte_cnt = 16'h1234;
   logic [15:0] ptr_a = 16'h5678;
   logic [15:0] ptr_b = 16'h9ABC;
   logic [7:0]  rd_data;

   int n_tests = 0;
   int n_fail  = 0;
   logic [6:0] m_mask;
   int         m_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   rbseq_readback #(.CNT_W(16), .ADDR_W(16), .STATUS_BYTE(STAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_stb(rd_stb), .byte_cnt(byte_cnt), .ptr_a(ptr_a), .ptr_b(ptr_b),
      .rd_data(rd_data)
   );

   // R3 view table, computed from the live inputs
   function automatic logic [7:0] view(int idx);
      case (idx)
         0: return STAT;
         1: return byte_cnt[7:0];
         2: return byte_cnt[15:8];
         3: return ptr_a[7:0];
         4: return ptr_a[15:8];
         5: return ptr_b[7:0];
         6: return ptr_b[15:8];
         default: return 8'h00;
      endcase
   endfunction

   function automatic int first_of(logic [6:0] m);
      for (int i = 0; i < 7; i++) if (m[i]) return i;
      return 0;
   endfunction

   function automatic int after(logic [6:0] m, int cur);
      for (int k = 1; k <= 7; k++) if (m[(cur + k) % 7]) return (cur + k) % 7;
      return cur;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: rd_data=%02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_data = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic set_mask(logic [7:0] d);
      wr(8'hBB); wr(d);
      m_mask = d[6:0];
      m_idx  = first_of(m_mask);
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); v = rd_data; rd_stb = 1'b0;
   endtask

   task automatic rd_check(string req);
      logic [7:0] v, e;
      e = (m_mask == 0) ? 8'h00 : view(m_idx);
      rd(v);
      check(req, v, e);
      if (m_mask != 0) m_idx = after(m_mask, m_idx);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: rd_data=%02h expected completion", rd_data);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_mask = 7'h7F; m_idx = 0;
      // R1 reset state
      rd_check("R1 reset status"); rd_check("R1 reset cnt lo"); rd_check("R1 reset cnt hi");

      // R5 reload mid-sequence
      set_mask(8'h7F);
      rd_check("R5 reload"); rd_check("R5 reload 2");
      set_mask(8'h7F);
      rd_check("R5 back to lowest");

      // R2 unarmed write ignored
      set_mask(8'h02);
      wr(8'h7F);
      rd_check("R2 unarmed ignored"); rd_check("R2 unarmed ignored again");

      // R2 double arm code: second becomes mask 0x3B
      wr(8'hBB); wr(8'hBB); m_mask = 7'h3B; m_idx = 0;
      for (int i = 0; i < 7; i++) rd_check("R2 arm code as mask");

      // R7 live inputs without a read
      set_mask(8'h08);
      rd_check("R7 a lo before");
      ptr_a = 16'h56C3;
      @(negedge clk);
      check("R7 live a lo", rd_data, 8'hC3);
      ptr_a = 16'h5678;

      // R8 held strobe
      set_mask(8'h12);
      @(negedge clk); rd_stb = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check("R8 held steady", rd_data, byte_cnt[7:0]);
      end
      rd_stb = 1'b0;
      @(negedge clk);
      check("R8 single advance", rd_data, ptr_a[15:8]);
      @(negedge clk);
      check("R8 no further advance", rd_data, ptr_a[15:8]);

      // R3 R4 R6 sweep over every mask, bit 7 toggled
      for (int m = 0; m < 128; m++) begin
         set_mask(8'(m) | ((m % 2 == 1) ? 8'h80 : 8'h00));
         for (int r = 0; r < 9; r++)
            rd_check((m == 0) ? "R6 empty mask" : "R4 R3 sweep");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule